// File: doc/BRIEF.md
# Configurable Quasi-Bidirectional I/O Port

This block is the drive controller behind one small microcontroller I/O port. For each pin it decides whether the pad's pull-up transistor and its pull-down transistor are switched on. That decision rests on four things: an output data latch, two per-bit configuration registers (A and B), per-bit alternate-function enable and data inputs, and a parameter mask of pins that must stay open-drain. It also brings the level on each pin back through a two-flop synchronizer, so the pin can be read through the same register interface that loads the latch and the configuration bits.

Each pin runs in one of four modes, chosen by its own pair of configuration bits:

- **Push-pull** drives both levels actively.
- **Open-drain** only ever sinks.
- **High-impedance** releases the pad so it can be used as an input.
- **Quasi-bidirectional** works like open-drain, except that the pull-up is pulsed for exactly one clock after the pin's output value rises. The external pull-up then holds the high level.

The port width is a parameter. Full ports are 8 bits and a short port is 5 bits.

Top module: `qb_port`

## Requirements
- R1: After a synchronous active-low reset, the latch reads all ones, both configuration registers read zero (every pin quasi-bidirectional), and both `pu_en` and `pd_en` are zero.
- R2: With `wr_en` high at a clock edge, `wr_sel` = 0 loads the latch, 1 loads configuration A and 2 loads configuration B. The read mux is combinational: `rd_sel` = 0, 1 and 2 return those registers and `rd_sel` = 3 returns the synchronized pins.
- R3: Mode {A,B} = 00 is quasi-bidirectional. `pd_en` is the inverse of the effective output. `pu_en` goes high for exactly one cycle after the effective output rises and is low otherwise. All pad enables are registered, so they follow the effective output by one clock.
- R4: Mode {A,B} = 01 is push-pull: `pu_en` equals the effective output and `pd_en` equals its inverse.
- R5: Mode {A,B} = 11 is open-drain: `pu_en` is 0 and `pd_en` is the inverse of the effective output.
- R6: Mode {A,B} = 10 is high-impedance: `pu_en` and `pd_en` are both 0.
- R7: A pin whose bit is set in `FORCE_OD_MASK` behaves as open-drain whatever its configuration bits hold. Its pull-up never fires.
- R8: The effective output of a pin is `alt_dat` when both `alt_en` and the latch bit are 1. Otherwise it is the latch bit. A rise that comes from `alt_dat` also starts the quasi-bidirectional pulse.
- R9: A pin level becomes visible on `rd_data` with `rd_sel` = 3 after two clock edges. A latch read returns the latch contents regardless of the pin levels.
- R10: `pu_en` and `pd_en` of a pin are never both high.
- R11: Each pin follows its own configuration bits independently of its neighbours, and the block works the same at `WIDTH` = 5 as at `WIDTH` = 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 latch, 1 configuration A, 2 configuration B |
| wr_data | input | WIDTH | Write data |
| rd_sel | input | 2 | Read source: 0 latch, 1 configuration A, 2 configuration B, 3 synchronized pins |
| rd_data | output | WIDTH | Read data |
| alt_en | input | WIDTH | Per-pin alternate-function enable |
| alt_dat | input | WIDTH | Per-pin alternate-function output value |
| pin_in | input | WIDTH | Pin levels from the pads |
| pu_en | output | WIDTH | Pull-up transistor enable per pin |
| pd_en | output | WIDTH | Pull-down transistor enable per pin |

## Verification
The bench builds two copies of the block side by side on shared stimulus:
- one at `WIDTH` = 8 with `FORCE_OD_MASK` = 8'hF0;
- one at `WIDTH` = 5 with `FORCE_OD_MASK` = 5'b00011.

Together they give forced and free pins at both widths. Because the port is only 8 bits wide, every latch value can be swept through every uniform mode and four mixed per-pin mode patterns. This exercises every rise and fall of every pin from every prior value, so each quasi-bidirectional pulse and its expiry can be checked against an arithmetic model.

// File: rtl/qb_port_pkg.sv
// Package: shared encodings for the quasi-bidirectional port.
// Assumes the per-pin mode is formed as {cfg_a, cfg_b}.
package qb_port_pkg;

    typedef enum logic [1:0] {
        PM_QUASI = 2'b00,
        PM_PUSH  = 2'b01,
        PM_HIZ   = 2'b10,
        PM_OPEN  = 2'b11
    } pad_mode_e;

    typedef enum logic [1:0] {
        RS_LATCH = 2'b00,
        RS_CFGA  = 2'b01,
        RS_CFGB  = 2'b10,
        RS_PINS  = 2'b11
    } reg_sel_e;

endpackage

// File: rtl/qb_port_regs.sv
// Register file of the port: the output latch and configuration A and B.
// Assumes a single write strobe; a select value of RS_PINS writes nothing.
module qb_port_regs
    import qb_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] cfga_q,
    output logic [WIDTH-1:0] cfgb_q
);

    // Load the selected register; reset gives latch ones and quasi mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '1;
            cfga_q  <= '0;
            cfgb_q  <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                RS_LATCH: latch_q <= wr_data;
                RS_CFGA:  cfga_q  <= wr_data;
                RS_CFGB:  cfgb_q  <= wr_data;
                default:  ;
            endcase
        end
    end

    // R2: a latch write is visible one edge later.
    assert_latch_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == RS_LATCH) |=> (latch_q == $past(wr_data)));

endmodule

// File: rtl/qb_pin_sync.sv
// Multi-stage synchronizer for the pin levels read back through the port.
// Assumes STAGES >= 1; each stage is a plain register bank.
module qb_pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic             armed_q;

    // Shift pin levels through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
            armed_q <= 1'b0;
        end else begin
            stage_q[0] <= pin_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            armed_q <= 1'b1;
        end
    end

    assign pin_sync = stage_q[STAGES-1];

    // R9: each stage holds what its predecessor held one edge earlier.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage_chk
        if (s == 0) begin : g_first
            assert_sync_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
                armed_q |-> (stage_q[0] == $past(pin_in)));
        end else begin : g_rest
            assert_sync_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
                armed_q |-> (stage_q[s] == $past(stage_q[s-1])));
        end
    end

endmodule

// File: rtl/qb_pin_drive.sv
// Drive logic for one pin: selects the effective output value, decodes the
// mode and produces registered pull-up and pull-down enables.
// Assumes FORCE_OD pins are wired to an open bus and must never pull up.
module qb_pin_drive
    import qb_port_pkg::*;
#(
    parameter bit FORCE_OD = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_a,
    input  logic cfg_b,
    input  logic latch_bit,
    input  logic alt_en,
    input  logic alt_dat,
    output logic pu_en,
    output logic pd_en
);

    pad_mode_e mode;
    logic      eff;
    logic      prev_q;
    logic      pu_d, pd_d;
    logic      pu_q, pd_q;

    // Resolve the mode, with the forced pins pinned to open-drain.
    always_comb mode = FORCE_OD ? PM_OPEN : pad_mode_e'({cfg_a, cfg_b});

    // The alternate function owns the pin only while the latch bit is 1.
    always_comb eff = (alt_en && latch_bit) ? alt_dat : latch_bit;

    // Next transistor enables from the mode and the effective value.
    always_comb begin
        pu_d = 1'b0;
        pd_d = ~eff;
        case (mode)
            PM_QUASI: pu_d = eff & ~prev_q;
            PM_PUSH:  pu_d = eff;
            PM_HIZ:   pd_d = 1'b0;
            default:  ;
        endcase
    end

    // Register the enables and remember the last effective value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            pu_q   <= 1'b0;
            pd_q   <= 1'b0;
        end else begin
            prev_q <= eff;
            pu_q   <= pu_d;
            pd_q   <= pd_d;
        end
    end

    assign pu_en = pu_q;
    assign pd_en = pd_q;

    // R10: the two transistors never fight.
    assert_no_crowbar_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pu_q && pd_q));

    // R3: outside push-pull, a pull-up pulse lasts a single cycle.
    assert_pulse_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_q && mode != PM_PUSH) |=> !pu_q);

    // R5: open-drain (also the forced case of R7) never pulls up.
    assert_open_no_pullup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_OPEN) |=> !pu_q);

    // R6: high-impedance releases both transistors.
    assert_hiz_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_HIZ) |=> (!pu_q && !pd_q));

endmodule

// File: rtl/qb_port.sv
// Top of the configurable port: register file, pin synchronizer, one drive
// slice per pin, and the read-back mux.
// Assumes FORCE_OD_MASK is sized to WIDTH; set bits mark bus pins.
module qb_port
    import qb_port_pkg::*;
#(
    parameter int               WIDTH         = 8,
    parameter int               SYNC_STAGES   = 2,
    parameter logic [WIDTH-1:0] FORCE_OD_MASK = 8'hF0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] alt_en,
    input  logic [WIDTH-1:0] alt_dat,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pu_en,
    output logic [WIDTH-1:0] pd_en
);

    logic [WIDTH-1:0] latch_q, cfga_q, cfgb_q, pin_sync;

    qb_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .latch_q (latch_q),
        .cfga_q  (cfga_q),
        .cfgb_q  (cfgb_q)
    );

    qb_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_sync (pin_sync)
    );

    // One drive slice per pin; the mask picks the forced variant.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        qb_pin_drive #(.FORCE_OD(FORCE_OD_MASK[i])) u_drive (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_a     (cfga_q[i]),
            .cfg_b     (cfgb_q[i]),
            .latch_bit (latch_q[i]),
            .alt_en    (alt_en[i]),
            .alt_dat   (alt_dat[i]),
            .pu_en     (pu_en[i]),
            .pd_en     (pd_en[i])
        );
    end

    // Combinational read-back of the selected source.
    always_comb begin
        case (reg_sel_e'(rd_sel))
            RS_LATCH: rd_data = latch_q;
            RS_CFGA:  rd_data = cfga_q;
            RS_CFGB:  rd_data = cfgb_q;
            default:  rd_data = pin_sync;
        endcase
    end

endmodule

// File: tb/qb_port_test.sv
`timescale 1ns/1ps
module qb_port_test;

    localparam logic [7:0] MASK_W = 8'hF0;
    localparam logic [4:0] MASK_N = 5'b00011;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_sel = '0;
    logic [7:0] alt_en = '0;
    logic [7:0] alt_dat = '0;
    logic [7:0] pin_in = '0;
    logic [7:0] rd_data, pu_en, pd_en;
    logic [4:0] n_rd, n_pu, n_pd;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] lat = 8'hFF;
    logic [7:0] cur_a = '0;
    logic [7:0] cur_b = '0;

    always #2 clk = ~clk;

    qb_port #(.WIDTH(8), .SYNC_STAGES(2), .FORCE_OD_MASK(MASK_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .alt_en(alt_en), .alt_dat(alt_dat), .pin_in(pin_in),
        .pu_en(pu_en), .pd_en(pd_en)
    );

    qb_port #(.WIDTH(5), .SYNC_STAGES(2), .FORCE_OD_MASK(MASK_N)) uut_narrow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data[4:0]), .rd_sel(rd_sel), .rd_data(n_rd),
        .alt_en(alt_en[4:0]), .alt_dat(alt_dat[4:0]), .pin_in(pin_in[4:0]),
        .pu_en(n_pu), .pd_en(n_pd)
    );

    function automatic logic [7:0] exp_pu(input logic [7:0] a, b, eff, prev, forced);
        logic [7:0] quasi, push;
        quasi = ~a & ~b;
        push  = ~a & b;
        return ((push & eff) | (quasi & eff & ~prev)) & ~forced;
    endfunction

    function automatic logic [7:0] exp_pd(input logic [7:0] a, b, eff, forced);
        logic [7:0] hiz;
        hiz = a & ~b;
        return ~eff & ~(hiz & ~forced);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Compare both instances' enables against the model.
    task automatic chk_pads(input string tag, input logic [7:0] eff, input logic [7:0] prev);
        chk(tag, pu_en, exp_pu(cur_a, cur_b, eff, prev, MASK_W));
        chk(tag, pd_en, exp_pd(cur_a, cur_b, eff, MASK_W));
        chk(tag, {3'b0, n_pu}, exp_pu(cur_a, cur_b, eff, prev, {3'b0, MASK_N}) & 8'h1F);
        chk(tag, {3'b0, n_pd}, exp_pd(cur_a, cur_b, eff, {3'b0, MASK_N}) & 8'h1F);
        chk("R10", pu_en & pd_en, 8'h00);
        chk("R7", {pu_en & MASK_W, pd_en & MASK_W}, {8'h00, ~eff & MASK_W});
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd_sel = 2'd0; #1;
        chk("R1", rd_data, 8'hFF);
        chk("R1", {3'b0, n_rd}, 8'h1F);
        chk("R1", pu_en | pd_en, 8'h00);
        chk("R1", {3'b0, n_pu | n_pd}, 8'h00);
        rd_sel = 2'd1; #1;
        chk("R1", rd_data, 8'h00);
        rd_sel = 2'd2; #1;
        chk("R1", rd_data, 8'h00);
        rd_sel = 2'd0;

        // R3 R4 R5 R6 R11: every latch value under uniform and mixed modes
        for (int m = 0; m < 8; m++) begin
            string tag;
            if (m < 4) begin
                cur_a = {8{m[1]}};
                cur_b = {8{m[0]}};
            end else begin
                cur_a = 8'(m * 8'h47 + 8'h1C);
                cur_b = 8'(m * 8'h9D + 8'h61);
            end
            tag = (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R6" :
                  (m == 3) ? "R5" : "R11";
            wr(2'd1, cur_a);
            wr(2'd2, cur_b);
            rd_sel = 2'd1; #1;
            chk("R2", rd_data, cur_a);
            chk("R2", {3'b0, n_rd}, cur_a & 8'h1F);
            rd_sel = 2'd2; #1;
            chk("R2", rd_data, cur_b);
            rd_sel = 2'd0;
            @(negedge clk);
            for (int v = 0; v < 256; v++) begin
                pin_in = ~8'(v);
                wr(2'd0, 8'(v));
                #1;
                chk("R2", rd_data, 8'(v));
                chk("R9", {3'b0, n_rd}, 8'(v) & 8'h1F);
                @(negedge clk);
                chk_pads(tag, 8'(v), lat);
                @(negedge clk);
                chk_pads(tag, 8'(v), 8'(v));
                lat = 8'(v);
            end
        end

        // R8: alternate function under push-pull
        cur_a = 8'h00; cur_b = 8'hFF;
        wr(2'd1, cur_a);
        wr(2'd2, cur_b);
        for (int i = 0; i < 64; i++) begin
            logic [7:0] l, e, d, eff;
            l = 8'(i * 53 + 7);
            e = 8'(i * 37 + 11);
            d = 8'(i * 91 + 5);
            alt_en = e; alt_dat = d;
            wr(2'd0, l);
            @(negedge clk);
            eff = l & (~e | d);
            chk_pads("R8", eff, eff);
        end

        // R8: a rise from the alternate data starts the quasi pulse
        cur_a = 8'h00; cur_b = 8'h00;
        wr(2'd1, cur_a);
        wr(2'd2, cur_b);
        wr(2'd0, 8'hFF);
        alt_en = 8'hFF; alt_dat = 8'h00;
        repeat (2) @(negedge clk);
        chk_pads("R8", 8'h00, 8'h00);
        alt_dat = 8'hFF;
        @(negedge clk);
        chk_pads("R8", 8'hFF, 8'h00);
        @(negedge clk);
        chk_pads("R8", 8'hFF, 8'hFF);
        alt_en = 8'h00;

        // R9: two-edge pin synchronizer
        rd_sel = 2'd3;
        begin
            logic [7:0] old;
            @(negedge clk);
            @(negedge clk);
            #1;
            old = rd_data;
            for (int i = 0; i < 32; i++) begin
                logic [7:0] p;
                p = 8'(i * 29 + 3);
                pin_in = p;
                @(negedge clk);
                chk("R9", rd_data, old);
                @(negedge clk);
                chk("R9", rd_data, p);
                chk("R9", {3'b0, n_rd}, p & 8'h1F);
                old = p;
            end
        end
        report();
    end

endmodule